// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block drives the enable line of an external power-management chip. Software first sets an arm bit in the configuration word. When the block then sees a pulse from the second alarm comparator, it drops the enable line to its off level. Software is expected to program that alarm at least two seconds ahead of the current time, so that the alarm registers are loaded before the next time update. The calendar comparison that produces the pulse is outside this block.

While power is off, the block watches four wake inputs. Each input has its own enable bit and its own polarity bit. A set polarity bit makes the input active low, and that is the reset default. Every input passes through a two-flop synchronizer before its level is judged. When an enabled input reaches its active level, the enable line returns to on. Each alarm pulse also latches a status flag. Software clears the flag by writing a one to it, and the flag raises an interrupt when the interrupt-enable bit is set.

The control state machine has two states. `ST_ON` drives the enable line high. It moves to `ST_OFF` on the transition *alarm-off*, which requires the arm bit to be set and an alarm pulse to arrive. `ST_OFF` drives the enable line low. It moves back to `ST_ON` on the transition *wake-on*, which requires an enabled, synchronized wake input at its active level. In every other case each state holds.

Top module: `pwr_alarm_ctl`

## Requirements
- R1: After reset `power_en` is 1, the arm bit (configuration bit 16) is 0, wake enables (bits 3:0) are 0, polarity bits (bits 7:4) are all 1, and `alm_flag` and `irq` are 0.
- R2: With the arm bit set and the block on, an `alm2_hit` pulse sampled at a clock edge makes `power_en` 0 right after that edge.
- R3: With the arm bit clear, an `alm2_hit` pulse leaves `power_en` at 1.
- R4: Every `alm2_hit` pulse sets `alm_flag` (status bit 7), whether or not the arm bit is set. A write to the status address (0x44) with bit 7 set clears the flag. A write with bit 7 clear leaves it unchanged.
- R5: `irq` is 1 exactly when `alm_flag` is 1 and the interrupt-enable bit (bit 4 at address 0x48) is 1.
- R6: When an alarm pulse and a status clear fall in the same cycle, the flag ends set.
- R7: While off, an enabled wake pin at its active level sets `power_en` to 1. A set polarity bit means active low, and a clear polarity bit means active high. The configuration word is at address 0x98.
- R8: A wake pin whose enable bit is clear has no effect. An active wake pin while the block is on also has no effect.
- R9: A change on a wake pin reaches `power_en` on the third rising edge after it is applied, and not earlier.
- R10: An alarm pulse while the block is already off keeps `power_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alm2_hit | input | 1 | One-cycle second-alarm match pulse |
| wake_pin | input | 4 | Asynchronous wake inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| power_en | output | 1 | Enable line to the power chip (1 = on) |
| alm_flag | output | 1 | Latched alarm status flag |
| irq | output | 1 | Alarm interrupt |

## Verification
Two functions can act in the same cycle. One is the alarm pulse setting the status flag. The other is a software write-one-to-clear of that same flag. The bench first sets the flag, then drives `alm2_hit` together with a status write whose bit 7 is set, both at one clock edge. It expects `alm_flag` to read 1 afterwards, and it expects a later clear issued on its own to bring the flag to 0. A second overlap is an armed alarm that arrives while a wake pin is already active in the on state. The bench expects the block to go off at that edge and to come back on one edge later.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
    localparam int N_WAKE      = 4;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 8'h98;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 8'h48;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h44;
    localparam int BIT_ARM     = 16;
    localparam int BIT_FLAG    = 7;
    localparam int BIT_IEN     = 4;
    localparam int POL_LSB     = N_WAKE;

    typedef enum logic [0:0] {
        ST_ON  = 1'b0,
        ST_OFF = 1'b1
    } pwr_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= rst_val;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= rst_val;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] act_low,
    output logic             any_wake
);
    logic [WIDTH-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            assign hit[i] = enable[i] & (act_low[i] ? ~level[i] : level[i]);
        end
    endgenerate

    assign any_wake = |hit;
endmodule

// File: rtl/pwrctl_regs.sv
module pwrctl_regs
    import pwrctl_pkg::*;
#(
    parameter int NW = N_WAKE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alm2_hit,
    output logic              arm,
    output logic [NW-1:0]     wake_en,
    output logic [NW-1:0]     wake_pol,
    output logic              alm_flag,
    output logic              irq
);
    logic ien_q;
    logic clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm      <= 1'b0;
            wake_en  <= '0;
            wake_pol <= '1;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG) begin
                arm      <= wr_data[BIT_ARM];
                wake_en  <= wr_data[NW-1:0];
                wake_pol <= wr_data[POL_LSB +: NW];
            end
            if (wr_addr == ADDR_IEN) ien_q <= wr_data[BIT_IEN];
        end
    end

    assign clr_req = wr_en && (wr_addr == ADDR_STAT) && wr_data[BIT_FLAG];

    // Set has priority over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        alm_flag <= 1'b0;
        else if (alm2_hit) alm_flag <= 1'b1;
        else if (clr_req)  alm_flag <= 1'b0;
    end

    assign irq = alm_flag & ien_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm2_hit |=> alm_flag);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm2_hit && clr_req) |=> alm_flag);
endmodule

// File: rtl/pwr_alarm_ctl.sv
module pwr_alarm_ctl
    import pwrctl_pkg::*;
#(
    parameter int NW          = N_WAKE,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alm2_hit,
    input  logic [NW-1:0]     wake_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              power_en,
    output logic              alm_flag,
    output logic              irq
);
    logic          arm;
    logic [NW-1:0] wake_en;
    logic [NW-1:0] wake_pol;
    logic [NW-1:0] wake_sync_lvl;
    logic          any_wake;
    pwr_state_t    state_q, state_d;

    pwrctl_regs #(.NW(NW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .alm2_hit (alm2_hit),
        .arm      (arm),
        .wake_en  (wake_en),
        .wake_pol (wake_pol),
        .alm_flag (alm_flag),
        .irq      (irq)
    );

    wake_sync #(.WIDTH(NW), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_pin),
        .rst_val  ({NW{1'b1}}),
        .sync_out (wake_sync_lvl)
    );

    wake_detect #(.WIDTH(NW)) u_det (
        .level    (wake_sync_lvl),
        .enable   (wake_en),
        .act_low  (wake_pol),
        .any_wake (any_wake)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:  if (arm && alm2_hit) state_d = ST_OFF;
            ST_OFF: if (any_wake)        state_d = ST_ON;
            default: state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ON:   power_en = 1'b1;
            ST_OFF:  power_en = 1'b0;
            default: power_en = 1'b1;
        endcase
    end

    // R2
    armed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && arm && alm2_hit) |=> !power_en);

    // R3
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && !arm) |=> power_en);

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alm_flag);

    // R7
    wake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_en && any_wake) |=> power_en);

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_en && !any_wake) |=> !power_en);
endmodule

// File: tb/pwr_alarm_ctl_tb.sv
module pwr_alarm_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alm2_hit = 1'b0;
    logic [3:0]  wake_pin = 4'hF;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic        power_en, alm_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_alarm_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .alm2_hit(alm2_hit), .wake_pin(wake_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .power_en(power_en), .alm_flag(alm_flag), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_alarm();
        @(negedge clk);
        alm2_hit = 1'b1;
        @(negedge clk);
        alm2_hit = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 power_en", power_en, 1'b1);
        check("R1 flag", alm_flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        // wake pins low would be active under default polarity; enables are 0
        wake_pin = 4'h0;
        pulse_alarm();
        check("R1 arm clear: alarm ignored", power_en, 1'b1);
        wake_pin = 4'hF;
        reg_wr(8'h44, 32'h80);
        check("R1 flag cleared", alm_flag, 1'b0);
    endtask

    task automatic t_unarmed();
        pulse_alarm();
        check("R3 unarmed stays on", power_en, 1'b1);
        check("R4 flag set unarmed", alm_flag, 1'b1);
        check("R5 irq off while ien=0", irq, 1'b0);
        reg_wr(8'h44, 32'h00);
        check("R4 write 0 keeps flag", alm_flag, 1'b1);
        reg_wr(8'h48, 32'h10);
        check("R5 irq with ien", irq, 1'b1);
        reg_wr(8'h44, 32'h80);
        check("R4 w1c", alm_flag, 1'b0);
        check("R5 irq drops", irq, 1'b0);
    endtask

    task automatic t_off_wake_low();
        // arm, enable pin0, all pins active-low
        reg_wr(8'h98, 32'h0001_00F1);
        pulse_alarm();
        check("R2 armed alarm off", power_en, 1'b0);
        pulse_alarm();
        check("R10 alarm while off", power_en, 1'b0);
        @(negedge clk); wake_pin[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 not yet after two edges", power_en, 1'b0);
        @(negedge clk);
        check("R7 active-low wake on", power_en, 1'b1);
        wake_pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        reg_wr(8'h44, 32'h80);
    endtask

    task automatic t_active_high_and_disabled();
        // pin2 active-high enabled; pin1 disabled
        wake_pin[2] = 1'b0;
        repeat (3) @(negedge clk);
        reg_wr(8'h98, 32'h0001_00B4);
        pulse_alarm();
        check("R2 off again", power_en, 1'b0);
        wake_pin[1] = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 disabled pin ignored", power_en, 1'b0);
        wake_pin[1] = 1'b1;
        wake_pin[2] = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 active-high wake on", power_en, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 wake while on no effect", power_en, 1'b1);
    endtask

    task automatic t_same_cycle();
        reg_wr(8'h98, 32'h0000_00F0);
        pulse_alarm();
        check("R6 pre-set", alm_flag, 1'b1);
        @(negedge clk);
        alm2_hit = 1'b1; wr_en = 1'b1; wr_addr = 8'h44; wr_data = 32'h80;
        @(negedge clk);
        alm2_hit = 1'b0; wr_en = 1'b0;
        check("R6 set beats clear", alm_flag, 1'b1);
        reg_wr(8'h44, 32'h80);
        check("R6 later clear", alm_flag, 1'b0);
    endtask

    task automatic t_alarm_with_wake_on();
        // pin3 active-high enabled and already high while on
        wake_pin[3] = 1'b1;
        reg_wr(8'h98, 32'h0001_0078);
        repeat (3) @(negedge clk);
        check("R8 active pin while on", power_en, 1'b1);
        pulse_alarm();
        check("R2 off despite active wake", power_en, 1'b0);
        @(negedge clk);
        check("R7 wake returns on", power_en, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_off_wake_low();
        t_active_high_and_disabled();
        t_same_cycle();
        t_alarm_with_wake_on();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule